// File: doc/BRIEF.md
# Dual-Channel UART Host Register Front-End

This block sits between a CPU bus and the register space of a two-channel UART. It decodes which channel an access targets and routes each access to that channel's small register file. Each file holds a line control byte, a two-byte baud divisor and a scratch byte. A static strap picks one of two bus styles. In the split-select style, each channel has its own active-low select, and pulling both selects low writes both channels at the same moment. In the shared-select style, there is one active-low select, and address bit 3 chooses the channel.

When a channel's divisor is entirely zero and divisor access is open, reads of the two divisor offsets return a fixed device identity and a revision code instead of the stored bytes. Software can use this to probe which part it is talking to.

A small state machine latches the bus style while reset is held. It has three states:
- `ST_RESET` is the state entered on reset. No access takes effect in it.
- `ST_SPLIT_CS` handles the split-select style.
- `ST_SHARED_CS` handles the shared-select style.

The machine has three transitions. Any state goes to `ST_RESET` when reset is sampled high. On the first clock after reset is released, `ST_RESET` goes to `ST_SPLIT_CS` when the latched style is 0, or to `ST_SHARED_CS` when it is 1. Both `ST_SPLIT_CS` and `ST_SHARED_CS` then hold until the next reset.

Top module: `duart_host_front`

## Requirements
- R1: A synchronous active-high reset clears the line control, divisor and scratch bytes of both channels to 0x00. No access takes effect in the first clock after reset is released.
- R2: When `cs_a_n` and `cs_b_n` are both high, no register is written, and `rdata` is 0x00 in either bus style.
- R3: In split-select style (`bus_mode` latched 0), `cs_a_n` low alone accesses channel A, and `cs_b_n` low alone accesses channel B.
- R4: In split-select style with both selects low, a write updates the addressed register in both channels on the same clock edge.
- R5: In split-select style with both selects low, a read returns channel A's data and raises `rd_misuse`. `rd_misuse` is low in every other case.
- R6: In shared-select style, `cs_a_n` is the only select. With it low, `addr[3]`=0 picks A and `addr[3]`=1 picks B. `cs_b_n` has no effect in this style.
- R7: In split-select style, `addr[3]` plays no part in channel choice.
- R8: When a channel's line control bit 7 is set and its two divisor bytes are both 0x00, reading offset 1 returns the identity 0x0A.
- R9: Under the same condition, reading offset 0 returns the revision code 0x01.
- R10: Register offsets are taken from `addr[2:0]`: 0 is the low divisor, 1 is the high divisor, 3 is line control, and 7 is scratch. Offsets 0 and 1 reach the divisor only while line control bit 7 is 1. Otherwise they read 0x00 and writes to them are dropped.
- R11: `bus_mode` is sampled only while reset is high. Changing it afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_mode | input | 1 | Bus style strap: 0 selects split-select, 1 selects shared-select |
| cs_a_n | input | 1 | Channel A select, or the shared select in shared-select style (active low) |
| cs_b_n | input | 1 | Channel B select (active low); ignored in shared-select style |
| addr | input | 4 | Register offset in bits 2:0; channel bit in bit 3 |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| rd_misuse | output | 1 | High during a read with both selects low in split-select style |

## Verification
The hardest case to reach is proving that `bus_mode` is really frozen after reset. From the ports, a frozen strap looks the same as a strap that happens not to change. The bench therefore flips `bus_mode` right after every reset release. It then runs accesses whose results differ between the two styles:
- a read through `addr[3]` with `cs_b_n` high;
- a read with both selects low, expecting no misuse flag.

The identity readback is reached in three ways: straight out of reset, by writing a divisor byte so that the identity disappears, and by writing the byte back to zero so that it returns.

// File: rtl/duart_pkg.sv
package duart_pkg;

    typedef enum logic [1:0] {
        ST_RESET     = 2'd0,
        ST_SPLIT_CS  = 2'd1,
        ST_SHARED_CS = 2'd2
    } front_state_t;

    localparam int unsigned NUM_CH     = 2;
    localparam int unsigned OFF_W      = 3;
    localparam logic [2:0]  OFF_DIV_LO = 3'd0;
    localparam logic [2:0]  OFF_DIV_HI = 3'd1;
    localparam logic [2:0]  OFF_LINE   = 3'd3;
    localparam logic [2:0]  OFF_SCR    = 3'd7;
    localparam int unsigned DIV_EN_BIT = 7;

endpackage

// File: rtl/duart_mode_fsm.sv
module duart_mode_fsm
    import duart_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic mode_in,
    output logic access_en,
    output logic single_mode
);

    front_state_t state_q, state_d;
    logic         mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RESET;
            mode_q  <= mode_in;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d     = state_q;
        access_en   = 1'b0;
        single_mode = mode_q;
        unique case (state_q)
            ST_RESET: begin
                state_d = mode_q ? ST_SHARED_CS : ST_SPLIT_CS;
            end
            ST_SPLIT_CS: begin
                access_en = 1'b1;
            end
            ST_SHARED_CS: begin
                access_en = 1'b1;
            end
            default: begin
                state_d = ST_RESET;
            end
        endcase
    end

endmodule

// File: rtl/duart_chan_decode.sv
module duart_chan_decode (
    input  logic access_en,
    input  logic single_mode,
    input  logic cs_a_n,
    input  logic cs_b_n,
    input  logic chan_bit,
    output logic sel_a,
    output logic sel_b
);

    always_comb begin
        sel_a = 1'b0;
        sel_b = 1'b0;
        if (access_en) begin
            if (single_mode) begin
                sel_a = !cs_a_n && !chan_bit;
                sel_b = !cs_a_n &&  chan_bit;
            end else begin
                sel_a = !cs_a_n;
                sel_b = !cs_b_n;
            end
        end
    end

endmodule

// File: rtl/duart_chan_regs.sv
module duart_chan_regs
    import duart_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata_raw,
    output logic              id_mode
);

    logic [DATA_W-1:0] div_lo_q, div_hi_q, line_q, scr_q;
    logic              div_en;

    assign div_en = line_q[DIV_EN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            div_lo_q <= '0;
            div_hi_q <= '0;
            line_q   <= '0;
            scr_q    <= '0;
        end else if (we) begin
            case (off)
                OFF_DIV_LO: if (div_en) div_lo_q <= wdata;
                OFF_DIV_HI: if (div_en) div_hi_q <= wdata;
                OFF_LINE:   line_q <= wdata;
                OFF_SCR:    scr_q  <= wdata;
                default:    ;
            endcase
        end
    end

    always_comb begin
        case (off)
            OFF_DIV_LO: rdata_raw = div_en ? div_lo_q : '0;
            OFF_DIV_HI: rdata_raw = div_en ? div_hi_q : '0;
            OFF_LINE:   rdata_raw = line_q;
            OFF_SCR:    rdata_raw = scr_q;
            default:    rdata_raw = '0;
        endcase
    end

    assign id_mode = div_en && (div_lo_q == '0) && (div_hi_q == '0);

endmodule

// File: rtl/duart_host_front.sv
module duart_host_front
    import duart_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4,
    parameter logic [7:0]  DEV_ID = 8'h0A,
    parameter logic [7:0]  REV_ID = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_mode,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rd_misuse
);

    localparam int unsigned CH_BIT = OFF_W;

    logic              access_en, single_mode;
    logic              sel_a, sel_b;
    logic [OFF_W-1:0]  off;
    logic [NUM_CH-1:0] sel_vec, id_mode;
    logic [DATA_W-1:0] raw_data [NUM_CH];
    logic [DATA_W-1:0] ch_data  [NUM_CH];

    assign off     = addr[OFF_W-1:0];
    assign sel_vec = {sel_b, sel_a};

    duart_mode_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .mode_in     (bus_mode),
        .access_en   (access_en),
        .single_mode (single_mode)
    );

    duart_chan_decode u_dec (
        .access_en   (access_en),
        .single_mode (single_mode),
        .cs_a_n      (cs_a_n),
        .cs_b_n      (cs_b_n),
        .chan_bit    (addr[CH_BIT]),
        .sel_a       (sel_a),
        .sel_b       (sel_b)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        duart_chan_regs #(.DATA_W(DATA_W)) u_regs (
            .clk       (clk),
            .rst       (rst),
            .we        (wr && sel_vec[ch]),
            .off       (off),
            .wdata     (wdata),
            .rdata_raw (raw_data[ch]),
            .id_mode   (id_mode[ch])
        );

        always_comb begin
            ch_data[ch] = raw_data[ch];
            if (id_mode[ch]) begin
                if (off == OFF_DIV_HI)      ch_data[ch] = DATA_W'(DEV_ID);
                else if (off == OFF_DIV_LO) ch_data[ch] = DATA_W'(REV_ID);
            end
        end
    end

    always_comb begin
        if (sel_a)      rdata = ch_data[0];
        else if (sel_b) rdata = ch_data[1];
        else            rdata = '0;
    end

    assign rd_misuse = rd && sel_a && sel_b;

endmodule

// File: rtl/duart_front_chk.sv
module duart_front_chk #(
    parameter int unsigned DATA_W = 8,
    parameter logic [7:0]  DEV_ID = 8'h0A
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_a_n,
    input logic              cs_b_n,
    input logic [3:0]        addr,
    input logic              rd,
    input logic [DATA_W-1:0] rdata,
    input logic              rd_misuse,
    input logic              single_mode,
    input logic              sel_a,
    input logic              sel_b,
    input logic [1:0]        id_mode
);

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (cs_a_n && cs_b_n) |-> (rdata == '0));

    p_misuse_cause_r5: assert property (@(posedge clk) disable iff (rst)
        rd_misuse |-> (!single_mode && !cs_a_n && !cs_b_n && rd));

    p_shared_excl_r6: assert property (@(posedge clk) disable iff (rst)
        single_mode |-> !(sel_a && sel_b));

    p_mode_hold_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(single_mode));

    p_id_code_r8: assert property (@(posedge clk) disable iff (rst)
        (sel_a && !sel_b && rd && addr[2:0] == 3'd1 && id_mode[0])
            |-> (rdata == DATA_W'(DEV_ID)));

endmodule

bind duart_host_front duart_front_chk #(.DATA_W(DATA_W), .DEV_ID(DEV_ID)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_a_n      (cs_a_n),
    .cs_b_n      (cs_b_n),
    .addr        (addr),
    .rd          (rd),
    .rdata       (rdata),
    .rd_misuse   (rd_misuse),
    .single_mode (single_mode),
    .sel_a       (sel_a),
    .sel_b       (sel_b),
    .id_mode     (id_mode)
);

// File: tb/sim_duart_host_front.sv
module sim_duart_host_front;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_mode = 1'b0;
    logic       cs_a_n = 1'b1, cs_b_n = 1'b1;
    logic [3:0] addr = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rd_misuse;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [7:0] d;
        logic       m;
        string      tag;
    } item_t;

    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    duart_host_front u0 (
        .clk(clk), .rst(rst), .bus_mode(bus_mode), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
        .addr(addr), .wr(wr), .rd(rd), .wdata(wdata), .rdata(rdata), .rd_misuse(rd_misuse)
    );

    task automatic drive(input logic ca, input logic cb, input logic [3:0] a,
                         input logic w, input logic r, input logic [7:0] d);
        @(negedge clk);
        cs_a_n = ca; cs_b_n = cb; addr = a; wr = w; rd = r; wdata = d;
    endtask

    task automatic wr_reg(input logic ca, input logic cb, input logic [3:0] a, input logic [7:0] d);
        drive(ca, cb, a, 1'b1, 1'b0, d);
    endtask

    task automatic rd_chk(input logic ca, input logic cb, input logic [3:0] a,
                          input logic [7:0] e, input logic em, input string tag);
        item_t it;
        drive(ca, cb, a, 1'b0, 1'b1, 8'h00);
        it.d = e; it.m = em; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic do_reset(input logic mode);
        drive(1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 8'h00);
        rst = 1'b1; bus_mode = mode;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        bus_mode = !mode;              // R11: strap flipped after release
        repeat (2) @(negedge clk);
    endtask

    // monitor: compares scoreboard items away from the clock edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                checks++;
                if (rdata !== it.d || rd_misuse !== it.m) begin
                    errors++;
                    $display("FAIL %s: rdata=%h misuse=%b expected rdata=%h misuse=%b",
                             it.tag, rdata, rd_misuse, it.d, it.m);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // ---------------- split-select style ----------------
        do_reset(1'b0);
        rd_chk(1'b0, 1'b1, 4'h7, 8'h00, 1'b0, "R1 scratch A after reset");
        rd_chk(1'b1, 1'b0, 4'h3, 8'h00, 1'b0, "R1 line ctl B after reset");
        wr_reg(1'b0, 1'b0, 4'h3, 8'h80);                  // broadcast divisor access on
        rd_chk(1'b0, 1'b1, 4'h1, 8'h0A, 1'b0, "R8 identity A");
        rd_chk(1'b0, 1'b1, 4'h0, 8'h01, 1'b0, "R9 revision A");
        rd_chk(1'b1, 1'b0, 4'h1, 8'h0A, 1'b0, "R8 identity B (R4 broadcast line ctl)");
        rd_chk(1'b1, 1'b0, 4'h0, 8'h01, 1'b0, "R9 revision B");
        wr_reg(1'b0, 1'b1, 4'h7, 8'h5A);
        wr_reg(1'b1, 1'b0, 4'h7, 8'hC3);
        rd_chk(1'b0, 1'b1, 4'h7, 8'h5A, 1'b0, "R3 scratch A");
        rd_chk(1'b1, 1'b0, 4'h7, 8'hC3, 1'b0, "R3 scratch B");
        rd_chk(1'b0, 1'b0, 4'h7, 8'h5A, 1'b1, "R5 both-low read");
        wr_reg(1'b1, 1'b1, 4'h7, 8'hFF);
        rd_chk(1'b1, 1'b1, 4'h7, 8'h00, 1'b0, "R2 deselected read");
        rd_chk(1'b0, 1'b1, 4'h7, 8'h5A, 1'b0, "R2 A untouched");
        rd_chk(1'b1, 1'b0, 4'h7, 8'hC3, 1'b0, "R2 B untouched");
        wr_reg(1'b0, 1'b1, 4'hF, 8'h11);
        rd_chk(1'b0, 1'b1, 4'h7, 8'h11, 1'b0, "R7 addr3 ignored, A written");
        rd_chk(1'b1, 1'b0, 4'h7, 8'hC3, 1'b0, "R7 B untouched");
        rd_chk(1'b0, 1'b1, 4'hF, 8'h11, 1'b0, "R7 addr3 ignored on read");
        wr_reg(1'b0, 1'b0, 4'h7, 8'h66);
        rd_chk(1'b0, 1'b1, 4'h7, 8'h66, 1'b0, "R4 broadcast A");
        rd_chk(1'b1, 1'b0, 4'h7, 8'h66, 1'b0, "R4 broadcast B");
        wr_reg(1'b0, 1'b1, 4'h0, 8'h34);
        rd_chk(1'b0, 1'b1, 4'h0, 8'h34, 1'b0, "R10 low divisor A");
        rd_chk(1'b0, 1'b1, 4'h1, 8'h00, 1'b0, "R8 no identity with nonzero divisor");
        rd_chk(1'b1, 1'b0, 4'h1, 8'h0A, 1'b0, "R8 identity B kept");
        wr_reg(1'b0, 1'b1, 4'h3, 8'h03);
        rd_chk(1'b0, 1'b1, 4'h0, 8'h00, 1'b0, "R10 divisor hidden");
        rd_chk(1'b0, 1'b1, 4'h3, 8'h03, 1'b0, "R10 line ctl A");
        wr_reg(1'b0, 1'b1, 4'h0, 8'h99);
        wr_reg(1'b0, 1'b1, 4'h3, 8'h80);
        rd_chk(1'b0, 1'b1, 4'h0, 8'h34, 1'b0, "R10 hidden write dropped");
        wr_reg(1'b0, 1'b1, 4'h0, 8'h00);
        rd_chk(1'b0, 1'b1, 4'h1, 8'h0A, 1'b0, "R8 identity returns");
        rd_chk(1'b0, 1'b1, 4'h0, 8'h01, 1'b0, "R9 revision returns");

        // ---------------- shared-select style ----------------
        do_reset(1'b1);
        rd_chk(1'b0, 1'b1, 4'h7, 8'h00, 1'b0, "R1 scratch A cleared");
        rd_chk(1'b0, 1'b1, 4'h3, 8'h00, 1'b0, "R1 line ctl A cleared");
        wr_reg(1'b0, 1'b1, 4'h7, 8'h21);
        wr_reg(1'b0, 1'b1, 4'hF, 8'h42);
        rd_chk(1'b0, 1'b1, 4'h7, 8'h21, 1'b0, "R6 addr3=0 picks A");
        rd_chk(1'b0, 1'b1, 4'hF, 8'h42, 1'b0, "R6 addr3=1 picks B / R11 style kept");
        rd_chk(1'b1, 1'b1, 4'hF, 8'h00, 1'b0, "R6 select high no access");
        rd_chk(1'b0, 1'b0, 4'h7, 8'h21, 1'b0, "R6 cs_b_n ignored, no misuse (R11)");
        wr_reg(1'b1, 1'b0, 4'h7, 8'hEE);
        rd_chk(1'b0, 1'b1, 4'h7, 8'h21, 1'b0, "R6 cs_b_n alone writes nothing A");
        rd_chk(1'b0, 1'b1, 4'hF, 8'h42, 1'b0, "R6 cs_b_n alone writes nothing B");

        drive(1'b1, 1'b1, 4'h0, 1'b0, 1'b0, 8'h00);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule